// File: doc/BRIEF.md
# ModRM Effective Address Generator

This block sits in the decode path of a 16-bit x86-style core. It takes a ModRM byte from a byte-wide instruction fetch stream. It then pulls in the zero, one or two displacement bytes that this byte calls for, and resolves where the operand lives. The operand is either a general register, named by the low three bits, or a memory location given as a segment:offset pair. The offset is built from the base and index registers and the displacement. The segment is DS or SS, and the block picks between them from the addressing form.

Fetch bytes are taken over a valid/ready handshake. The base, index and segment register values come in on plain input ports and are read in the cycle the result is presented. When the operand location is ready, the block raises a one-cycle done pulse. In that cycle the packed result, the register-operand flag and both three-bit field indices are valid. The middle field of the ModRM byte is passed through unchanged. The surrounding decoder uses it to name the other operand.

Top module: `modrm_ea_gen`

## Requirements
- R1: When reset is asserted, and in the idle state reached after reset is released, `done` is 0 and `fetch_ready` is 1.
- R2: In the done cycle, `reg_idx` equals ModRM bits 5:3 and `rm_idx` equals ModRM bits 2:0.
- R3: A ModRM byte with bits 7:6 = 11 fetches no displacement. `done` rises in the cycle after the ModRM handshake, with `is_reg` = 1 and `ea` = 0.
- R4: Bits 7:6 = 00 with bits 2:0 = 110 is the direct form. It takes two displacement bytes, low byte first, and gives `ea` = {DS, displacement} with no register added.
- R5: Any other form with bits 7:6 = 00 fetches no displacement. `done` rises in the cycle after the ModRM handshake.
- R6: Bits 7:6 = 01 fetch one displacement byte, which is sign-extended to 16 bits before it is added.
- R7: Bits 7:6 = 10 fetch two displacement bytes, low byte first, and add them as a 16-bit value.
- R8: For memory forms other than the direct one, the base sum selected by bits 2:0 is: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. The displacement is added to it, and the result appears in `ea[15:0]`.
- R9: `ea[31:16]` is SS for rm 2, 3 and 6 (except the direct form), and DS for every other memory form.
- R10: The offset sum wraps modulo 65536. Carries out of bit 15 are lost.
- R11: `done` is high for exactly one cycle, in the cycle after the last byte of the operand is accepted. `fetch_ready` is 0 in that cycle, so a byte offered then is not taken, and it is 1 in every other cycle.
- R12: While a displacement byte is awaited and `fetch_valid` is low, the block waits without advancing and without raising `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_valid | input | 1 | Fetch byte is offered |
| fetch_data | input | 8 | Fetch byte (ModRM, then displacement low, then high) |
| fetch_ready | output | 1 | Block can take a fetch byte this cycle |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_ds | input | 16 | DS value |
| seg_ss | input | 16 | SS value |
| done | output | 1 | One-cycle pulse, result valid |
| is_reg | output | 1 | Operand is a register named by `rm_idx` |
| rm_idx | output | 3 | ModRM bits 2:0 |
| reg_idx | output | 3 | ModRM bits 5:3 |
| ea | output | 32 | {segment, offset}, zero for register operands |

## Verification
All 32 combinations of mod and rm are driven with two register and displacement sets. The first set has a negative byte displacement and sums that carry past bit 15. The second has a positive byte displacement and different DS/SS values, so a wrong segment choice or a missing sign extension shows up. Between fetch bytes the bench leaves gaps of zero to two idle cycles. These gaps separate a block that waits correctly from one that counts cycles instead of handshakes. Every done cycle offers a junk byte, which would be accepted if ready were wrongly high. A reset in the middle of a displacement fetch, followed by a register-form operation, shows that no partial state survives.

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLO  = 2'd1,
    ST_DHI  = 2'd2,
    ST_DONE = 2'd3
  } ea_state_t;

  typedef enum logic [1:0] {
    DSP_NONE   = 2'd0,
    DSP_NARROW = 2'd1,
    DSP_WIDE   = 2'd2
  } disp_kind_t;

  // Displacement size implied by a ModRM byte
  function automatic disp_kind_t disp_kind_of(input logic [7:0] mrm);
    disp_kind_t k;
    unique case (mrm[7:6])
      2'b00:   k = (mrm[2:0] == 3'b110) ? DSP_WIDE : DSP_NONE;
      2'b01:   k = DSP_NARROW;
      2'b10:   k = DSP_WIDE;
      default: k = DSP_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/modrm_ea_ctrl.sv
module modrm_ea_ctrl
  import modrm_ea_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [BYTE_W-1:0] fetch_data,
  output logic              fetch_ready,
  output logic              done,
  output logic [7:0]        modrm_q,
  output disp_kind_t        kind_q,
  output logic              lo_en,
  output logic              hi_en
);

  ea_state_t  state_q, state_d;
  disp_kind_t kind_d;
  logic       cap_en;

  assign cap_en = (state_q == ST_IDLE) && fetch_valid;
  assign kind_d = disp_kind_of(fetch_data[7:0]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fetch_valid) state_d = (kind_d == DSP_NONE) ? ST_DONE : ST_DLO;
      ST_DLO:  if (fetch_valid) state_d = (kind_q == DSP_WIDE) ? ST_DHI : ST_DONE;
      ST_DHI:  if (fetch_valid) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modrm_q <= '0;
      kind_q  <= DSP_NONE;
    end else if (cap_en) begin
      modrm_q <= fetch_data[7:0];
      kind_q  <= kind_d;
    end
  end

  assign fetch_ready = (state_q != ST_DONE);
  assign done        = (state_q == ST_DONE);
  assign lo_en       = (state_q == ST_DLO) && fetch_valid;
  assign hi_en       = (state_q == ST_DHI) && fetch_valid;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DLO || state_q == ST_DHI) && !fetch_valid) |=> $stable(state_q));

  // R3
  reg_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fetch_valid && fetch_data[7:6] == 2'b11) |=> done);

endmodule

// File: rtl/modrm_disp_asm.sv
module modrm_disp_asm
  import modrm_ea_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic [BYTE_W-1:0] byte_in,
  input  disp_kind_t        kind,
  output logic [DISP_W-1:0] disp
);

  localparam int HI_W = DISP_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= byte_in[HI_W-1:0];
  end

  always_comb begin
    unique case (kind)
      DSP_NARROW: disp = {{HI_W{lo_q[BYTE_W-1]}}, lo_q};
      DSP_WIDE:   disp = {hi_q, lo_q};
      default:    disp = '0;
    endcase
  end

endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc #(
  parameter int ADDR_W = 16,
  localparam int EA_W  = 2 * ADDR_W
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        rm,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] bx,
  input  logic [ADDR_W-1:0] bp,
  input  logic [ADDR_W-1:0] si,
  input  logic [ADDR_W-1:0] di,
  input  logic [ADDR_W-1:0] ds,
  input  logic [ADDR_W-1:0] ss,
  output logic              is_reg,
  output logic [EA_W-1:0]   ea
);

  logic [ADDR_W-1:0] base_sum, offset, seg;
  logic              direct, bp_based;

  always_comb begin
    unique case (rm)
      3'd0: base_sum = bx + si;
      3'd1: base_sum = bx + di;
      3'd2: base_sum = bp + si;
      3'd3: base_sum = bp + di;
      3'd4: base_sum = si;
      3'd5: base_sum = di;
      3'd6: base_sum = bp;
      default: base_sum = bx;
    endcase
  end

  assign is_reg   = (mode == 2'b11);
  assign direct   = (mode == 2'b00) && (rm == 3'd6);
  assign bp_based = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6);

  always_comb begin
    if (direct) begin
      offset = disp;
      seg    = ds;
    end else begin
      offset = base_sum + disp;
      seg    = bp_based ? ss : ds;
    end
  end

  assign ea = is_reg ? '0 : {seg, offset};

endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
  import modrm_ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int EA_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [BYTE_W-1:0] fetch_data,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  input  logic [ADDR_W-1:0] seg_ds,
  input  logic [ADDR_W-1:0] seg_ss,
  output logic              done,
  output logic              is_reg,
  output logic [2:0]        rm_idx,
  output logic [2:0]        reg_idx,
  output logic [EA_W-1:0]   ea
);

  logic              rst_meta_q, rst_sync_n;
  logic [7:0]        modrm_q;
  disp_kind_t        kind_q;
  logic              lo_en, hi_en;
  logic [ADDR_W-1:0] disp;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  modrm_ea_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_ready(fetch_ready), .done(done),
    .modrm_q(modrm_q), .kind_q(kind_q),
    .lo_en(lo_en), .hi_en(hi_en)
  );

  modrm_disp_asm #(.BYTE_W(BYTE_W), .DISP_W(ADDR_W)) disp_i (
    .clk(clk), .rst_n(rst_sync_n),
    .lo_en(lo_en), .hi_en(hi_en),
    .byte_in(fetch_data), .kind(kind_q), .disp(disp)
  );

  modrm_ea_calc #(.ADDR_W(ADDR_W)) calc_i (
    .mode(modrm_q[7:6]), .rm(modrm_q[2:0]), .disp(disp),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .ds(seg_ds), .ss(seg_ss),
    .is_reg(is_reg), .ea(ea)
  );

  assign rm_idx  = modrm_q[2:0];
  assign reg_idx = modrm_q[5:3];

  // R9
  ss_select_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !is_reg && !(modrm_q[7:6] == 2'b00 && modrm_q[2:0] == 3'd6) &&
     (modrm_q[2:0] == 3'd2 || modrm_q[2:0] == 3'd3 || modrm_q[2:0] == 3'd6))
    |-> (ea[EA_W-1:ADDR_W] == seg_ss));

  // R3
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && is_reg) |-> (ea == '0));

  // R4
  direct_seg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && modrm_q[7:6] == 2'b00 && modrm_q[2:0] == 3'd6)
    |-> (ea[EA_W-1:ADDR_W] == seg_ds));

endmodule

// File: tb/modrm_ea_gen_tb.sv
`timescale 1ns/1ps
module modrm_ea_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [7:0]  fetch_data;
  logic        fetch_ready;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, seg_ds, seg_ss;
  logic        done, is_reg;
  logic [2:0]  rm_idx, reg_idx;
  logic [31:0] ea;

  int n_checks = 0;
  int n_errors = 0;
  bit mdl_done = 0;
  bit finished = 0;

  modrm_ea_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_ds(seg_ds), .seg_ss(seg_ss),
    .done(done), .is_reg(is_reg), .rm_idx(rm_idx), .reg_idx(reg_idx), .ea(ea)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int disp_len(input logic [7:0] m);
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10) return 2;
    if (m[7:6] == 2'b00 && m[2:0] == 3'd6) return 2;
    return 0;
  endfunction

  // Per-cycle comparison of handshake and done against the model
  task automatic chk_cycle();
    chk(fetch_ready == !mdl_done, "R11 ready", {31'd0, fetch_ready}, {31'd0, !mdl_done});
    chk(done == mdl_done, "R11 done", {31'd0, done}, {31'd0, mdl_done});
  endtask

  task automatic chk_result(input logic [7:0] m, input logic [15:0] d);
    int base, dv, sum;
    logic [15:0] sg;
    string tag;
    chk(reg_idx == m[5:3], "R2 reg_idx", {29'd0, reg_idx}, {29'd0, m[5:3]});
    chk(rm_idx == m[2:0], "R2 rm_idx", {29'd0, rm_idx}, {29'd0, m[2:0]});
    if (m[7:6] == 2'b11) begin
      chk(is_reg == 1'b1, "R3 is_reg", {31'd0, is_reg}, 32'd1);
      chk(ea == 32'd0, "R3 ea", ea, 32'd0);
    end else begin
      chk(is_reg == 1'b0, "R8 is_reg", {31'd0, is_reg}, 32'd0);
      if (m[7:6] == 2'b00 && m[2:0] == 3'd6) begin
        chk(ea == {seg_ds, d}, "R4 direct", ea, {seg_ds, d});
      end else begin
        case (m[2:0])
          3'd0: base = reg_bx + reg_si;
          3'd1: base = reg_bx + reg_di;
          3'd2: base = reg_bp + reg_si;
          3'd3: base = reg_bp + reg_di;
          3'd4: base = reg_si;
          3'd5: base = reg_di;
          3'd6: base = reg_bp;
          default: base = reg_bx;
        endcase
        if (m[7:6] == 2'b01) begin dv = (d[7] ? int'(d[7:0]) - 256 : int'(d[7:0])); tag = "R6 R8 offset"; end
        else if (m[7:6] == 2'b10) begin dv = int'(d); tag = "R7 R8 offset"; end
        else begin dv = 0; tag = "R5 R8 offset"; end
        sum = base + dv;
        if (sum >= 65536 || sum < 0) tag = {tag, " R10"};
        sum = ((sum % 65536) + 65536) % 65536;
        chk(ea[15:0] == 16'(sum), tag, {16'd0, ea[15:0]}, sum);
        sg = (m[2:0] == 3'd2 || m[2:0] == 3'd3 || m[2:0] == 3'd6) ? seg_ss : seg_ds;
        chk(ea[31:16] == sg, "R9 segment", {16'd0, ea[31:16]}, {16'd0, sg});
      end
    end
  endtask

  task automatic run_op(input logic [7:0] m, input logic [15:0] d, input int gap);
    logic [7:0] q[$];
    int idx = 0;
    int stall = 0;
    bit fin = 0;
    q.push_back(m);
    if (disp_len(m) >= 1) q.push_back(d[7:0]);
    if (disp_len(m) == 2) q.push_back(d[15:8]);
    while (!fin) begin
      @(negedge clk);
      chk_cycle();
      if (mdl_done) begin
        chk_result(m, d);
        fetch_valid = 1'b1;   // offered while not ready: must be ignored (R11)
        fetch_data  = 8'hAA;
        mdl_done = 0;
        fin = 1;
      end else if (idx < q.size() && stall >= gap) begin
        fetch_valid = 1'b1;
        fetch_data  = q[idx];
        idx++;
        stall = 0;
        mdl_done = (idx == q.size());
      end else begin
        fetch_valid = 1'b0;   // stall gap (R12)
        fetch_data  = 8'h55;
        stall++;
      end
    end
  endtask

  task automatic set_regs(input int s);
    if (s == 0) begin
      reg_bx = 16'h1234; reg_bp = 16'hFFF0; reg_si = 16'h0020;
      reg_di = 16'h8001; seg_ds = 16'h1000; seg_ss = 16'h2000;
    end else begin
      reg_bx = 16'hF000; reg_bp = 16'h0100; reg_si = 16'h9000;
      reg_di = 16'h0FFF; seg_ds = 16'hABCD; seg_ss = 16'h5555;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; mdl_done = 0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
    chk(fetch_ready == 1'b1, "R1 ready in reset", {31'd0, fetch_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done idle", {31'd0, done}, 32'd0);
    chk(fetch_ready == 1'b1, "R1 ready idle", {31'd0, fetch_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_data = 8'h00;
    set_regs(0);
    repeat (3) @(negedge clk);
    do_reset();
    for (int s = 0; s < 2; s++) begin
      set_regs(s);
      for (int md = 0; md < 4; md++) begin
        for (int rm = 0; rm < 8; rm++) begin
          logic [7:0] m;
          logic [15:0] d;
          m = {2'(md), 3'(rm + s * 3), 3'(rm)};
          if (md == 1) d = (s == 0) ? 16'h0080 : 16'h7F7F;
          else if (md == 2) d = (s == 0) ? 16'h8000 : 16'h1234;
          else d = (s == 0) ? 16'hBEEF : 16'h0FF0;
          run_op(m, d, (md + rm + s) % 3);
        end
      end
    end
    // Reset in the middle of a displacement fetch
    @(negedge clk);
    fetch_valid = 1'b1; fetch_data = 8'h80;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(done == 1'b0, "R12 waiting", {31'd0, done}, 32'd0);
    do_reset();
    run_op(8'hC5, 16'h0000, 0);
    run_op(8'h46, 16'h0012, 1);
    @(negedge clk);
    fetch_valid = 1'b0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule